// File: doc/BRIEF.md
# Countdown Timer with Alarm Compare

This block provides two time-keeping functions that share a packed BCD format of hours, minutes and seconds. The first is a countdown timer. Its six BCD digits step down by one second on each 1 Hz enable pulse while it runs. Borrows ripple across the mixed modulo-10 and modulo-6 digits. When the count reaches zero, the timer stops and raises a buzzer request.

The second function is an alarm. It holds an hours-and-minutes setting and compares it against the live clock time on the input port. The request is raised once, on the edge where the times first agree and the live seconds read zero, and only while the alarm enable is high.

Both values are set from single-cycle button pulses:
- One pulse selects the field (seconds, minutes or hours).
- One pulse steps the selected field up by one.
- A level input chooses whether a step goes to the timer or to the alarm.
- Further pulses start or stop the timer and clear the buzzer request.

The buzzer output is the OR of the two requests.

Top module: `countdownAlarm`

## Requirements
- R1: After reset the timer reads 00:00:00, the field select points at seconds, the timer is stopped, the stored alarm is 00:00 and the buzzer is low.
- R2: While the timer is stopped and editAlarm is low, each btnInc pulse steps the selected timer field up by one BCD count. Seconds and minutes wrap from 59 to 00 and hours wrap from 23 to 00, with no carry into any other field.
- R3: Each btnSel pulse advances the field select in the order seconds, minutes, hours, then back to seconds.
- R4: A btnRun pulse starts a stopped timer and stops a running one. A start request while the timer reads 00:00:00 is ignored.
- R5: While the timer runs, each tickEn pulse lowers it by exactly one second, visible on the cycle after the pulse. While it is stopped, tickEn leaves it unchanged.
- R6: When a units digit decrements from 0 it reloads 9, and a tens-of-seconds or tens-of-minutes digit reloads 5. Each reload borrows from the next digit up (for example, 01:00:00 becomes 00:59:59).
- R7: The tick that brings a running timer to 00:00:00 stops it and sets the buzzer request. The timer then holds at zero under further ticks.
- R8: btnInc pulses aimed at the timer are ignored while it runs.
- R9: With alarmEn high, the buzzer rises one cycle after curHours and curMins first equal the stored alarm while curSecs is 00. A match held steady after a clear does not raise it again.
- R10: With alarmEn low, or when the live minutes differ from the stored alarm, no alarm request is raised.
- R11: A btnClear pulse drops the buzzer on the next cycle, and it takes priority over a simultaneous set.
- R12: With editAlarm high, btnInc steps the alarm minutes or hours (same wrap rules as R2) and leaves the timer unchanged. A step with the seconds field selected does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle pulse once per second |
| curHours | input | 8 | Live clock hours, BCD |
| curMins | input | 8 | Live clock minutes, BCD |
| curSecs | input | 8 | Live clock seconds, BCD |
| btnSel | input | 1 | Pulse: advance the field select |
| btnInc | input | 1 | Pulse: step the selected field up |
| btnRun | input | 1 | Pulse: start or stop the timer |
| btnClear | input | 1 | Pulse: clear the buzzer request |
| editAlarm | input | 1 | Level: steps go to the alarm when high |
| alarmEn | input | 1 | Level: enables the alarm compare |
| tmrHours | output | 8 | Timer hours, BCD |
| tmrMins | output | 8 | Timer minutes, BCD |
| tmrSecs | output | 8 | Timer seconds, BCD |
| buzzer | output | 1 | Buzzer request (timer expiry OR alarm) |

## Verification
The hardest state to reach from the ports is a borrow that crosses several digits at once, for example from 10:00:00 down to 09:59:59. Reaching it requires the timer to be loaded through the same single-step button pulses that a user would press. The bench converts each preset into a count of presses per field, selects the fields in turn, and then starts the timer and issues one tick. The alarm's once-per-match behaviour is reached by holding a matching live time across a clear and confirming that the request stays low.

// File: rtl/cdal_pkg.sv
package cdal_pkg;
  localparam int DIG_W   = 4;
  localparam int N_TDIG  = 6;
  localparam int N_ADIG  = 4;

  typedef enum logic [1:0] {FLD_SEC = 2'd0, FLD_MIN = 2'd1, FLD_HR = 2'd2} field_e;

  typedef struct packed {
    logic   decTmr;
    logic   incTmr;
    logic   incAlm;
    field_e field;
    logic   clrReq;
  } strobe_t;

  // Limit of timer digit i, index 0 = seconds units, 5 = hours tens
  function automatic int digitLimit(input int i);
    case (i)
      1, 3:    return 5;
      5:       return 2;
      default: return 9;
    endcase
  endfunction
endpackage

// File: rtl/cdalDigit.sv
module cdalDigit #(
  parameter int W    = 4,
  parameter int MAXV = 9
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         dn,
  input  logic         up,
  input  logic         wrapZero,
  output logic [W-1:0] val,
  output logic         atZero,
  output logic         atMax
);
  localparam logic [W-1:0] LIM = W'(MAXV);

  assign atZero = (val == '0);
  assign atMax  = (val == LIM);

  always_ff @(posedge clk) begin
    if (!rstN)         val <= '0;
    else if (wrapZero) val <= '0;
    else if (dn)       val <= atZero ? LIM : val - W'(1);
    else if (up)       val <= atMax ? '0 : val + W'(1);
  end
endmodule

// File: rtl/cdalCtrl.sv
module cdalCtrl
  import cdal_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    tickEn,
  input  logic    btnSel,
  input  logic    btnInc,
  input  logic    btnRun,
  input  logic    btnClear,
  input  logic    editAlarm,
  input  logic    tmrZero,
  input  logic    tmrOne,
  output strobe_t strobe,
  output logic    timerReq
);
  logic   running;
  field_e fieldSel;
  logic   decNow;

  assign decNow = tickEn && running;

  always_comb begin
    strobe.decTmr = decNow;
    strobe.incTmr = btnInc && !editAlarm && !running;
    strobe.incAlm = btnInc && editAlarm;
    strobe.field  = fieldSel;
    strobe.clrReq = btnClear;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      fieldSel <= FLD_SEC;
      timerReq <= 1'b0;
    end else begin
      if (btnRun)                running <= running ? 1'b0 : !tmrZero;
      else if (decNow && tmrOne) running <= 1'b0;

      if (btnSel) begin
        case (fieldSel)
          FLD_SEC: fieldSel <= FLD_MIN;
          FLD_MIN: fieldSel <= FLD_HR;
          default: fieldSel <= FLD_SEC;
        endcase
      end

      if (btnClear)              timerReq <= 1'b0;
      else if (decNow && tmrOne) timerReq <= 1'b1;
    end
  end
endmodule

// File: rtl/cdalDatapath.sv
module cdalDatapath
  import cdal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strobe,
  input  logic       alarmEn,
  input  logic [7:0] curHours,
  input  logic [7:0] curMins,
  input  logic [7:0] curSecs,
  output logic [7:0] tmrHours,
  output logic [7:0] tmrMins,
  output logic [7:0] tmrSecs,
  output logic       tmrZero,
  output logic       tmrOne,
  output logic       alarmReq
);
  logic [DIG_W-1:0] tDig [N_TDIG];
  logic [N_TDIG-1:0] tZero, tMax, tDn, tUp;
  logic [DIG_W-1:0] aDig [N_ADIG];
  logic [N_ADIG-1:0] aZero, aMax, aUp;
  logic tHrWrap, aHrWrap, match, matchQ;

  assign tHrWrap = strobe.incTmr && strobe.field == FLD_HR && {tDig[5], tDig[4]} == 8'h23;
  assign aHrWrap = strobe.incAlm && strobe.field == FLD_HR && {aDig[3], aDig[2]} == 8'h23;

  for (genvar i = 0; i < N_TDIG; i++) begin : g_tmr
    if (i == 0) begin : g_lsd
      assign tDn[i] = strobe.decTmr;
    end else begin : g_upper
      assign tDn[i] = tDn[i-1] && tZero[i-1];
    end
    if (i % 2 == 0) begin : g_units
      assign tUp[i] = strobe.incTmr && (int'(strobe.field) == i / 2);
    end else begin : g_tens
      assign tUp[i] = tUp[i-1] && tMax[i-1];
    end
    cdalDigit #(.W(DIG_W), .MAXV(digitLimit(i))) u_dig (
      .clk(clk), .rstN(rstN), .dn(tDn[i]), .up(tUp[i]),
      .wrapZero(i >= 4 ? tHrWrap : 1'b0),
      .val(tDig[i]), .atZero(tZero[i]), .atMax(tMax[i])
    );
  end

  for (genvar j = 0; j < N_ADIG; j++) begin : g_alm
    if (j % 2 == 0) begin : g_units
      assign aUp[j] = strobe.incAlm && (int'(strobe.field) == j / 2 + 1);
    end else begin : g_tens
      assign aUp[j] = aUp[j-1] && aMax[j-1];
    end
    cdalDigit #(.W(DIG_W), .MAXV(digitLimit(j + 2))) u_dig (
      .clk(clk), .rstN(rstN), .dn(1'b0), .up(aUp[j]),
      .wrapZero(j >= 2 ? aHrWrap : 1'b0),
      .val(aDig[j]), .atZero(aZero[j]), .atMax(aMax[j])
    );
  end

  assign tmrSecs  = {tDig[1], tDig[0]};
  assign tmrMins  = {tDig[3], tDig[2]};
  assign tmrHours = {tDig[5], tDig[4]};
  assign tmrZero  = &tZero;
  assign tmrOne   = (&tZero[5:1]) && tDig[0] == DIG_W'(1);

  assign match = alarmEn && curSecs == 8'h00 &&
                 curHours == {aDig[3], aDig[2]} && curMins == {aDig[1], aDig[0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchQ   <= 1'b0;
      alarmReq <= 1'b0;
    end else begin
      matchQ <= match;
      if (strobe.clrReq)          alarmReq <= 1'b0;
      else if (match && !matchQ)  alarmReq <= 1'b1;
    end
  end
endmodule

// File: rtl/countdownAlarm.sv
module countdownAlarm
  import cdal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic [7:0] curHours,
  input  logic [7:0] curMins,
  input  logic [7:0] curSecs,
  input  logic       btnSel,
  input  logic       btnInc,
  input  logic       btnRun,
  input  logic       btnClear,
  input  logic       editAlarm,
  input  logic       alarmEn,
  output logic [7:0] tmrHours,
  output logic [7:0] tmrMins,
  output logic [7:0] tmrSecs,
  output logic       buzzer
);
  strobe_t strobe;
  logic tmrZero, tmrOne, timerReq, alarmReq;

  cdalCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .btnSel(btnSel), .btnInc(btnInc),
    .btnRun(btnRun), .btnClear(btnClear), .editAlarm(editAlarm),
    .tmrZero(tmrZero), .tmrOne(tmrOne), .strobe(strobe), .timerReq(timerReq)
  );

  cdalDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .alarmEn(alarmEn),
    .curHours(curHours), .curMins(curMins), .curSecs(curSecs),
    .tmrHours(tmrHours), .tmrMins(tmrMins), .tmrSecs(tmrSecs),
    .tmrZero(tmrZero), .tmrOne(tmrOne), .alarmReq(alarmReq)
  );

  assign buzzer = timerReq | alarmReq;
endmodule

// File: rtl/cdalChecker.sv
module cdalChecker (
  input logic       clk,
  input logic       rstN,
  input logic       tickEn,
  input logic       btnInc,
  input logic       btnClear,
  input logic       alarmEn,
  input logic [7:0] curSecs,
  input logic [7:0] tmrHours,
  input logic [7:0] tmrMins,
  input logic [7:0] tmrSecs,
  input logic       buzzer
);
  logic [23:0] tmrAll;
  assign tmrAll = {tmrHours, tmrMins, tmrSecs};

  // R2, R6: digits stay legal BCD within their field limits
  a_r6_legal_digits: assert property (@(posedge clk) disable iff (!rstN)
    tmrSecs[3:0] <= 4'd9 && tmrSecs[7:4] <= 4'd5 &&
    tmrMins[3:0] <= 4'd9 && tmrMins[7:4] <= 4'd5 &&
    tmrHours[3:0] <= 4'd9 && tmrHours <= 8'h23);

  a_r5_no_tick_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !btnInc) |=> $stable(tmrAll));

  a_r7_zero_holds: assert property (@(posedge clk) disable iff (!rstN)
    (tmrAll == 24'h0 && !btnInc) |=> tmrAll == 24'h0);

  a_r11_clear_drops: assert property (@(posedge clk) disable iff (!rstN)
    btnClear |=> !buzzer);

  // R9, R10: buzzer only rises after a tick or a qualified second-zero match
  a_r9_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(buzzer) |-> ($past(tickEn) || ($past(alarmEn) && $past(curSecs) == 8'h00)));
endmodule

bind countdownAlarm cdalChecker i_cdalChecker (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .btnInc(btnInc), .btnClear(btnClear),
  .alarmEn(alarmEn), .curSecs(curSecs), .tmrHours(tmrHours), .tmrMins(tmrMins),
  .tmrSecs(tmrSecs), .buzzer(buzzer)
);

// File: tb/test_countdownAlarm.sv
module test_countdownAlarm;
  logic clk = 1'b0;
  logic rstN, tickEn, btnSel, btnInc, btnRun, btnClear, editAlarm, alarmEn;
  logic [7:0] curHours, curMins, curSecs;
  logic [7:0] tmrHours, tmrMins, tmrSecs;
  logic buzzer;
  int checkCnt = 0;
  int failCnt  = 0;

  always #2 clk = ~clk;

  countdownAlarm i_countdownAlarm (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .curHours(curHours), .curMins(curMins),
    .curSecs(curSecs), .btnSel(btnSel), .btnInc(btnInc), .btnRun(btnRun),
    .btnClear(btnClear), .editAlarm(editAlarm), .alarmEn(alarmEn),
    .tmrHours(tmrHours), .tmrMins(tmrMins), .tmrSecs(tmrSecs), .buzzer(buzzer)
  );

  // {preset HHMMSS, expected after one tick, expected buzzer}
  localparam logic [48:0] VEC [8] = '{
    {24'h000005, 24'h000004, 1'b0},
    {24'h000010, 24'h000009, 1'b0},
    {24'h000100, 24'h000059, 1'b0},
    {24'h010000, 24'h005959, 1'b0},
    {24'h100000, 24'h095959, 1'b0},
    {24'h235959, 24'h235958, 1'b0},
    {24'h203000, 24'h202959, 1'b0},
    {24'h000001, 24'h000000, 1'b1}
  };

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int bcdToInt(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; tickEn = 0; btnSel = 0; btnInc = 0; btnRun = 0; btnClear = 0;
    editAlarm = 0; alarmEn = 0; curHours = 8'h12; curMins = 8'h34; curSecs = 8'h56;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic pulseInc(input int n);
    for (int k = 0; k < n; k++) begin
      btnInc = 1'b1; @(negedge clk); btnInc = 1'b0; @(negedge clk);
    end
  endtask
  task automatic pulseSel();  btnSel = 1;   @(negedge clk); btnSel = 0;   @(negedge clk); endtask
  task automatic pulseRun();  btnRun = 1;   @(negedge clk); btnRun = 0;   @(negedge clk); endtask
  task automatic pulseTick(); tickEn = 1;   @(negedge clk); tickEn = 0;   @(negedge clk); endtask
  task automatic pulseClr();  btnClear = 1; @(negedge clk); btnClear = 0; @(negedge clk); endtask

  // Field select starts at seconds and returns there
  task automatic loadFields(input logic [23:0] t);
    pulseInc(bcdToInt(t[7:0]));   pulseSel();
    pulseInc(bcdToInt(t[15:8]));  pulseSel();
    pulseInc(bcdToInt(t[23:16])); pulseSel();
  endtask

  function automatic logic [23:0] tmrNow();
    return {tmrHours, tmrMins, tmrSecs};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checkCnt++; failCnt++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    doReset();
    @(negedge clk);
    check("R1 timer", tmrNow(), 24'h0);
    check("R1 buzzer", {23'd0, buzzer}, 24'd0);

    // Table: load, start, one tick
    foreach (VEC[v]) begin
      doReset();
      loadFields(VEC[v][48:25]);
      check("R2 load", tmrNow(), VEC[v][48:25]);
      pulseRun();
      pulseTick();
      check("R5 R6 tick", tmrNow(), VEC[v][24:1]);
      check("R7 buzzer", {23'd0, buzzer}, {23'd0, VEC[v][0]});
    end
    // Last vector reached zero: further ticks hold, clear drops buzzer
    pulseTick();
    check("R7 hold zero", tmrNow(), 24'h0);
    check("R7 stays buzzing", {23'd0, buzzer}, 24'd1);
    pulseClr();
    check("R11 clear", {23'd0, buzzer}, 24'd0);
    pulseRun(); pulseTick();
    check("R4 start at zero ignored", tmrNow(), 24'h0);

    // Wraps without carry
    doReset();
    pulseInc(60);
    check("R2 sec wrap", tmrNow(), 24'h0);
    pulseSel(); pulseSel(); pulseInc(24);
    check("R2 hour wrap", tmrNow(), 24'h0);
    pulseSel(); pulseInc(1);
    check("R3 field back to sec", tmrNow(), 24'h000001);
    pulseSel(); pulseInc(1);
    check("R3 minutes next", tmrNow(), 24'h000101);

    // Running ignores steps, stop freezes
    doReset();
    pulseInc(30);
    pulseRun();
    pulseInc(1);
    check("R8 inc while running", tmrNow(), 24'h000030);
    pulseTick();
    check("R5 running tick", tmrNow(), 24'h000029);
    pulseRun(); pulseTick();
    check("R4 R5 stopped ignores tick", tmrNow(), 24'h000029);

    // Alarm set to 06:07
    doReset();
    editAlarm = 1'b1;
    pulseInc(3);
    pulseSel(); pulseInc(7);
    pulseSel(); pulseInc(6);
    pulseSel();
    editAlarm = 1'b0;
    check("R12 timer untouched", tmrNow(), 24'h0);
    alarmEn = 1'b0;
    curHours = 8'h06; curMins = 8'h07; curSecs = 8'h00;
    repeat (3) @(negedge clk);
    check("R10 disabled", {23'd0, buzzer}, 24'd0);
    curSecs = 8'h01; @(negedge clk);
    alarmEn = 1'b1; curMins = 8'h08; curSecs = 8'h00;
    repeat (2) @(negedge clk);
    check("R10 minute differs", {23'd0, buzzer}, 24'd0);
    curMins = 8'h07; @(negedge clk);
    check("R9 match", {23'd0, buzzer}, 24'd1);
    pulseClr();
    repeat (4) @(negedge clk);
    check("R9 once per match", {23'd0, buzzer}, 24'd0);

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule